// File: doc/BRIEF.md
# Cascadable Synchronous Counter with Offset Sequencing

This block is a binary up-counter built from one or more identical 4-bit stages. Each stage has a synchronous clear and a synchronous parallel load, which both act on the next rising clock edge. It also has two count-enable inputs and a carry output for chaining stages. Every stage shares the first enable. The second enable of each stage comes from the carry of the stage below it, so the chain counts as one wide binary counter.

A mode input sets how the chain sequences. In start-offset mode the chain's own carry forces a reload of a parameter start value. The count then runs from that value up to all ones and repeats. In end-offset mode a decoder compares the full state against a parameter terminal value and drives the clear. The count then runs from zero up to that value and repeats. In plain mode only the external clear and load act on the count.

Top module: `offset_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, `count` is 0 after that edge. With `count` at 0, `carry` is 0.
- R2: With `clr_n` and `ld_n` high and no offset action due, `count` increases by one modulo 2^W on an edge only when `en_p` and `en_t` are both 1. Otherwise it holds.
- R3: `carry` is 1 exactly when `en_t` is 1 and every bit of `count` is 1, in the same cycle and with no clock delay.
- R4: `clr_n` low at an edge makes `count` 0. This takes priority over load and over counting.
- R5: `ld_n` low with `clr_n` high makes `count` equal to `load_data` after the edge, whatever the enables.
- R6: With `mode_sel` = 1 (start offset), `count` all ones and both enables high, the next `count` is START_VAL. With the defaults the sequence is 6, 7, ..., 15, 6.
- R7: With `mode_sel` = 2 (end offset), `count` equal to TERM_VAL and both enables high, the next `count` is 0. With the defaults the sequence is 0, 1, ..., 13, 0.
- R8: With N_SLICES = 2 the chain behaves as one 8-bit counter. The upper stage advances only when the lower stage is at 1111 and both enables are high.
- R9: `mode_sel` = 0 and `mode_sel` = 3 both give plain operation, with no automatic reload and no automatic clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | 0/3 plain, 1 start offset, 2 end offset |
| clr_n | input | 1 | Synchronous active-low clear |
| ld_n | input | 1 | Synchronous active-low parallel load |
| en_p | input | 1 | Count enable shared by all stages |
| en_t | input | 1 | Count enable of the first stage; also qualifies the carry |
| load_data | input | SLICE_W*N_SLICES | Parallel load value |
| count | output | SLICE_W*N_SLICES | Current count |
| carry | output | 1 | Chain carry: all ones and `en_t` |

## Verification
Every change to `count` is due exactly one rising edge after the inputs that cause it. This holds for reset, clear, load, the offset reload, the terminal clear and counting. `carry` follows `count` and `en_t` in the same cycle with no clock delay. The bench changes its inputs one time unit after an edge and samples one time unit after the next edge. A model in the bench then predicts the next count from the previous prediction and the inputs that were held across that edge. The carry is checked against that prediction and the enables, while the inputs are still held.

// File: rtl/ctr_pkg.sv
// Shared definitions for the offset counter: the sequencing mode encoding.
package ctr_pkg;
    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_START = 2'd1,
        MODE_END   = 2'd2,
        MODE_SPARE = 2'd3
    } ctr_mode_e;
endpackage

// File: rtl/ctr_slice.sv
// One counter stage: synchronous reset, clear, load and a count gated by two enables.
// The carry is combinational. It is asserted at all ones and qualified by en_t.
// Assumes single clock domain; priority is reset > clear > load > count.
module ctr_slice #(
    parameter int unsigned SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          ld_n,
    input  logic          en_p,
    input  logic          en_t,
    input  logic [SW-1:0] d,
    output logic [SW-1:0] q,
    output logic          co
);
    localparam logic [SW-1:0] ONE = SW'(1);

    // State register with the four-level priority
    always_ff @(posedge clk) begin
        if (!rst_n)            q <= '0;
        else if (!clr_n)       q <= '0;
        else if (!ld_n)        q <= d;
        else if (en_p && en_t) q <= q + ONE;
    end

    // Carry for the next stage, gated by this stage's second enable
    always_comb co = en_t && (&q);
endmodule

// File: rtl/offset_ctrl.sv
// Offset sequencing control. In start mode the chain carry forces a reload of START_VAL.
// In end mode a full-width compare with TERM_VAL forces a clear.
// Both actions happen only when both enables are high. An external load supplies its own data.
module offset_ctrl
    import ctr_pkg::*;
#(
    parameter int unsigned W         = 4,
    parameter int unsigned START_VAL = 6,
    parameter int unsigned TERM_VAL  = 13
) (
    input  logic [1:0]   mode_sel,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic         en_p,
    input  logic         en_t,
    input  logic         chain_co,
    input  logic [W-1:0] count,
    input  logic [W-1:0] load_data,
    output logic         clr_eff_n,
    output logic         ld_eff_n,
    output logic [W-1:0] data_eff
);
    localparam logic [W-1:0] START_W = W'(START_VAL);
    localparam logic [W-1:0] TERM_W  = W'(TERM_VAL);

    ctr_mode_e mode;
    logic      run;
    logic      auto_clr;
    logic      auto_ld;

    // Mode decode and the combined run condition
    always_comb begin
        mode = ctr_mode_e'(mode_sel);
        run  = en_p && en_t;
    end

    // Terminal decode drives the synchronous clear
    always_comb auto_clr = (mode == MODE_END) && run && (count == TERM_W);

    // Chain carry drives the synchronous reload
    always_comb auto_ld = (mode == MODE_START) && en_p && chain_co;

    // Effective strobes and load data seen by the stages
    always_comb begin
        clr_eff_n = clr_n && !auto_clr;
        ld_eff_n  = ld_n && !auto_ld;
        data_eff  = (!ld_n) ? load_data : START_W;
    end
endmodule

// File: rtl/offset_counter.sv
// Top: a chain of N_SLICES stages plus the offset control.
// Stage k takes its second enable from the carry of stage k-1. The last carry is the chain carry.
// Assumes one clock and a synchronous active-low reset.
module offset_counter
    import ctr_pkg::*;
#(
    parameter int unsigned SLICE_W   = 4,
    parameter int unsigned N_SLICES  = 1,
    parameter int unsigned START_VAL = 6,
    parameter int unsigned TERM_VAL  = 13
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    mode_sel,
    input  logic                          clr_n,
    input  logic                          ld_n,
    input  logic                          en_p,
    input  logic                          en_t,
    input  logic [SLICE_W*N_SLICES-1:0]   load_data,
    output logic [SLICE_W*N_SLICES-1:0]   count,
    output logic                          carry
);
    localparam int unsigned W = SLICE_W * N_SLICES;

    logic          clr_eff_n;
    logic          ld_eff_n;
    logic [W-1:0]  data_eff;
    logic [N_SLICES:0] t_chain;

    // First stage takes the external second enable
    always_comb t_chain[0] = en_t;

    for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
        ctr_slice #(.SW(SLICE_W)) u_slice (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_n (clr_eff_n),
            .ld_n  (ld_eff_n),
            .en_p  (en_p),
            .en_t  (t_chain[k]),
            .d     (data_eff[k*SLICE_W +: SLICE_W]),
            .q     (count[k*SLICE_W +: SLICE_W]),
            .co    (t_chain[k+1])
        );
    end

    // Chain carry is the last stage's carry
    always_comb carry = t_chain[N_SLICES];

    offset_ctrl #(
        .W         (W),
        .START_VAL (START_VAL),
        .TERM_VAL  (TERM_VAL)
    ) u_ctrl (
        .mode_sel  (mode_sel),
        .clr_n     (clr_n),
        .ld_n      (ld_n),
        .en_p      (en_p),
        .en_t      (en_t),
        .chain_co  (carry),
        .count     (count),
        .load_data (load_data),
        .clr_eff_n (clr_eff_n),
        .ld_eff_n  (ld_eff_n),
        .data_eff  (data_eff)
    );
endmodule

// File: rtl/offset_counter_chk.sv
// Checker for offset_counter, attached by bind. It checks the port-level rules of each requirement.
module offset_counter_chk
    import ctr_pkg::*;
#(
    parameter int unsigned W         = 4,
    parameter int unsigned START_VAL = 6,
    parameter int unsigned TERM_VAL  = 13
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode_sel,
    input logic         clr_n,
    input logic         ld_n,
    input logic         en_p,
    input logic         en_t,
    input logic [W-1:0] load_data,
    input logic [W-1:0] count,
    input logic         carry
);
    localparam logic [W-1:0] START_W = W'(START_VAL);
    localparam logic [W-1:0] TERM_W  = W'(TERM_VAL);
    localparam logic [W-1:0] ONE_W   = W'(1);

    logic plain;
    always_comb plain = (mode_sel == MODE_PLAIN) || (mode_sel == MODE_SPARE);

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> count == '0); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ld_n && !(en_p && en_t)) |=> $stable(count)); // R2
    AST_PLAIN_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (plain && clr_n && ld_n && en_p && en_t) |=> count == $past(count) + ONE_W); // R9
    AST_CARRY_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> (&count)); // R3
    AST_CARRY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_t |-> !carry); // R3
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> count == '0); // R4
    AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !ld_n && !(mode_sel == MODE_END && en_p && en_t && count == TERM_W))
        |=> count == $past(load_data)); // R5
    AST_START_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MODE_START && clr_n && ld_n && en_p && en_t && (&count))
        |=> count == START_W); // R6
    AST_END_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MODE_END && ld_n && en_p && en_t && count == TERM_W)
        |=> count == '0); // R7
endmodule

bind offset_counter offset_counter_chk #(
    .W         (W),
    .START_VAL (START_VAL),
    .TERM_VAL  (TERM_VAL)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .clr_n     (clr_n),
    .ld_n      (ld_n),
    .en_p      (en_p),
    .en_t      (en_t),
    .load_data (load_data),
    .count     (count),
    .carry     (carry)
);

// File: tb/offset_counter_tb.sv
// Bench: a 4-bit instance (dut_i) and a two-stage 8-bit instance (dut_w), each checked against an arithmetic model.
module offset_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int unsigned B_START = 8'h3C;
    localparam int unsigned B_TERM  = 8'hC8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] a_mode = 2'd0, b_mode = 2'd0;
    logic a_clr = 1'b1, a_ld = 1'b1, a_p = 1'b0, a_t = 1'b0;
    logic b_clr = 1'b1, b_ld = 1'b1, b_p = 1'b0, b_t = 1'b0;
    logic [3:0] a_d = '0, a_q;
    logic [7:0] b_d = '0, b_q;
    logic a_co, b_co;

    int unsigned exp_a = 0, exp_b = 0;
    int n_checks = 0, n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    offset_counter dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(a_mode), .clr_n(a_clr), .ld_n(a_ld),
        .en_p(a_p), .en_t(a_t), .load_data(a_d), .count(a_q), .carry(a_co));

    offset_counter #(.SLICE_W(4), .N_SLICES(2), .START_VAL(B_START), .TERM_VAL(B_TERM)) dut_w (
        .clk(clk), .rst_n(rst_n), .mode_sel(b_mode), .clr_n(b_clr), .ld_n(b_ld),
        .en_p(b_p), .en_t(b_t), .load_data(b_d), .count(b_q), .carry(b_co));

    function automatic int unsigned model(int unsigned cur, int unsigned mask, int unsigned md,
            logic rst, logic clr, logic ld, logic p, logic t,
            int unsigned d, int unsigned sv, int unsigned tv);
        if (!rst || !clr) return 0;
        if (md == 2 && p && t && cur == tv) return 0;
        if (!ld) return d & mask;
        if (md == 1 && p && t && cur == mask) return sv;
        if (p && t) return (cur + 1) & mask;
        return cur;
    endfunction

    task automatic chk(string tag, int unsigned act, int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock: predict, wait past the edge, then compare counts and carries
    task automatic tick(string tag_a, string tag_b);
        int unsigned na, nb;
        na = model(exp_a, 15, a_mode, rst_n, a_clr, a_ld, a_p, a_t, a_d, 6, 13);
        nb = model(exp_b, 255, b_mode, rst_n, b_clr, b_ld, b_p, b_t, b_d, B_START, B_TERM);
        @(posedge clk);
        #1;
        exp_a = na;
        exp_b = nb;
        chk(tag_a, a_q, exp_a);
        chk(tag_b, b_q, exp_b);
        chk("R3 carry a", a_co, (a_t && exp_a == 15) ? 1 : 0);
        chk("R3 carry b", b_co, (b_t && exp_b == 255) ? 1 : 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        // R1: reset
        #1;
        for (int i = 0; i < 3; i++) tick("R1 reset a", "R1 reset b");
        rst_n = 1'b1;
        // R2: free count, 4-bit wraps
        a_p = 1; a_t = 1; b_p = 1; b_t = 1;
        for (int i = 0; i < 40; i++) tick("R2 count a", "R2 count b");
        // R2 and R3: enable combinations, including stall at all ones
        a_ld = 0; a_d = 4'hE; tick("R5 load a", "R2 count b");
        a_ld = 1;
        for (int c = 0; c < 16; c++) begin
            a_p = c[0]; a_t = c[1]; b_p = c[2]; b_t = c[3];
            for (int i = 0; i < 3; i++) tick("R2 enables a", "R2 enables b");
        end
        // R4: clear beats load and count
        a_clr = 0; b_clr = 0; a_ld = 0; b_ld = 0; a_p = 1; a_t = 1; b_p = 1; b_t = 1;
        a_d = 4'h9; b_d = 8'h99;
        tick("R4 clear a", "R4 clear b");
        a_clr = 1; b_clr = 1;
        // R5: load every value with various enables
        for (int v = 0; v < 16; v++) begin
            a_d = v[3:0]; b_d = 8'(v * 17); a_p = v[0]; a_t = v[1]; b_p = v[2]; b_t = v[3];
            tick("R5 load a", "R5 load b");
        end
        a_ld = 1; b_ld = 1; a_p = 1; a_t = 1; b_p = 1; b_t = 1;
        // R9: spare mode behaves as plain
        a_mode = 2'd3; b_mode = 2'd3;
        for (int i = 0; i < 20; i++) tick("R9 spare a", "R9 spare b");
        // R6: start offset, with occasional stalls
        a_mode = 2'd1; b_mode = 2'd1;
        for (int i = 0; i < 320; i++) begin
            a_p = (i % 7 != 3); b_t = (i % 11 != 5);
            tick("R6 start a", "R6 start b");
        end
        // R7: end offset, from zero
        a_clr = 0; b_clr = 0; tick("R4 clear a", "R4 clear b");
        a_clr = 1; b_clr = 1; a_mode = 2'd2; b_mode = 2'd2;
        for (int i = 0; i < 320; i++) begin
            a_t = (i % 9 != 4); b_p = (i % 13 != 6);
            tick("R7 end a", "R7 end b");
        end
        // R8: 8-bit cascade in plain mode over a full wrap
        a_mode = 2'd0; b_mode = 2'd0; a_p = 1; a_t = 1;
        b_clr = 0; tick("R2 count a", "R4 clear b");
        b_clr = 1;
        for (int i = 0; i < 330; i++) begin
            b_p = (i % 17 != 8); b_t = (i % 23 != 11);
            tick("R2 count a", "R8 cascade b");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule